// File: doc/BRIEF.md
# DMA Request Front End (Synchronizer and Sense Detector)

This block sits at the input of one DMA channel. It turns one of many asynchronous, active-low request lines into a single synchronous request flag that the channel's sequencing logic reads. A source-select code picks the request that feeds the channel. The code can name a software trigger instead of a wire.

The selected wire goes through a chain of flip-flops clocked by the system clock. A detector then works on the output of the last stage, in one of two senses. In falling-edge sense, a high-to-low transition latches the flag, and the flag stays latched until the channel acknowledges it. In low-level sense, the flag follows the line: it rises once the line has been seen low on two successive samples and falls one cycle after the line is seen high. The software trigger arrives as a one-cycle synchronous pulse. It skips the synchronizer and sets the flag directly in either sense.

Top module: `dreq_front`

## Requirements
- R1: Select code 0 names the software trigger, and codes 1 to 36 name hardware line `req_n[code-1]`. Lines that are not selected have no effect on `req_flag`.
- R2: Select codes 37 to 63 name no source. With such a code, neither the hardware lines nor `sw_trig` can raise `req_flag`.
- R3: In falling-edge sense (`sense_lvl`=0), suppose the selected line is first sampled low at rising edge k after being high. Then `req_flag` is low after edge k+1 and high after edge k+2.
- R4: In falling-edge sense, a set `req_flag` stays set whatever the selected line does afterwards, for as long as `req_clr` is low.
- R5: In falling-edge sense, `req_clr` high at a rising edge clears `req_flag`. If a new falling edge is detected at that same edge, the flag stays set.
- R6: In low-level sense (`sense_lvl`=1), suppose the line is first sampled low at edge k and stays low. Then `req_flag` is low after edge k+2 and high after edge k+3. A low pulse that the first stage samples only once never sets the flag.
- R7: In low-level sense, suppose the line is first sampled high at edge k. Then `req_flag` is still high after edge k+1 and low after edge k+2, unless a software trigger is active.
- R8: With code 0 selected, `sw_trig` high at a rising edge sets `req_flag` at that edge in both senses. In low-level sense with the selected line high, the flag lasts one cycle.
- R9: While `rst` is high, `req_flag` is low and every synchronizer stage is high. After release with the selected line high, no request appears.
- R10: In low-level sense, `req_clr` has no effect on `req_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_n | input | 36 | Asynchronous request lines, active low |
| sw_trig | input | 1 | Software trigger, one-cycle synchronous pulse |
| src_sel | input | 6 | Source-select code |
| sense_lvl | input | 1 | 0 = falling-edge sense, 1 = low-level sense |
| req_clr | input | 1 | Acknowledge strobe that clears a latched edge request |
| req_flag | output | 1 | Synchronous request flag |

## Verification
A stuck or skipped synchronizer stage shows as a flag that moves one edge early or late. The bench catches this within three or four cycles of a line change, because it samples on the exact expected cycle. A previous-sample register that is wrong after reset, or wrong between patterns, shows either as a spurious flag on a rising line or as a missing flag on a falling one. A hold term that is corrupted shows as the flag dropping while the line wanders, which is visible within a few cycles. A fault in select decoding shows as a flag raised by an unselected line or by a code outside the valid range. Each of these cases is swept for every select code.

// File: rtl/dreq_pkg.sv
package dreq_pkg;

    // Default channel geometry
    localparam int DEF_NUM_HW = 36;
    localparam int DEF_SEL_W  = 6;
    localparam int DEF_STAGES = 2;

    // Code that names the software trigger
    localparam int SW_CODE = 0;

    typedef enum logic {
        SENSE_EDGE  = 1'b0,
        SENSE_LEVEL = 1'b1
    } sense_e;

    // Selected source after the multiplexer
    typedef struct packed {
        logic line_n;   // chosen wire, active low, still asynchronous
        logic sw_hit;   // software trigger qualified by the select code
    } src_pick_t;

    // Hardware codes run from 1 up to num_hw
    function automatic logic code_is_hw(input int code, input int num_hw);
        return (code >= 1) && (code <= num_hw);
    endfunction

endpackage

// File: rtl/dreq_src_mux.sv
module dreq_src_mux
    import dreq_pkg::*;
#(
    parameter int NUM_HW = DEF_NUM_HW,
    parameter int SEL_W  = DEF_SEL_W
) (
    input  logic [NUM_HW-1:0] req_n,
    input  logic              sw_trig,
    input  logic [SEL_W-1:0]  src_sel,
    output src_pick_t         pick
);

    always_comb begin
        pick.line_n = 1'b1;
        pick.sw_hit = 1'b0;
        if (int'(src_sel) == SW_CODE) begin
            pick.sw_hit = sw_trig;
        end
        for (int i = 0; i < NUM_HW; i++) begin
            if (code_is_hw(int'(src_sel), NUM_HW) && (int'(src_sel) == i + 1)) begin
                pick.line_n = req_n[i];
            end
        end
    end

endmodule

// File: rtl/dreq_sync.sv
module dreq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_n,
    output logic first_n,
    output logic q_n
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= d_n;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign first_n = chain[0];
    assign q_n     = chain[STAGES-1];

endmodule

// File: rtl/dreq_detect.sv
module dreq_detect
    import dreq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  sense_e sense,
    input  logic   sync_n,
    input  logic   sw_hit,
    input  logic   clr,
    output logic   flag_q
);

    logic prev_n;
    logic fall;
    logic both_low;
    logic flag_d;

    assign fall     = prev_n & ~sync_n;
    assign both_low = ~prev_n & ~sync_n;

    always_comb begin
        unique case (sense)
            SENSE_LEVEL: flag_d = both_low | sw_hit;
            default:     flag_d = (flag_q & ~clr) | fall | sw_hit;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_n <= 1'b1;
            flag_q <= 1'b0;
        end else begin
            prev_n <= sync_n;
            flag_q <= flag_d;
        end
    end

endmodule

// File: rtl/dreq_front.sv
module dreq_front
    import dreq_pkg::*;
#(
    parameter int NUM_HW = DEF_NUM_HW,
    parameter int SEL_W  = DEF_SEL_W,
    parameter int STAGES = DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_HW-1:0] req_n,
    input  logic              sw_trig,
    input  logic [SEL_W-1:0]  src_sel,
    input  logic              sense_lvl,
    input  logic              req_clr,
    output logic              req_flag
);

    localparam int NUM_SRC = NUM_HW + 1;

    src_pick_t pick;
    logic      sync_first_n;
    logic      sync_n;
    sense_e    sense;

    assign sense = sense_e'(sense_lvl);

    dreq_src_mux #(
        .NUM_HW (NUM_HW),
        .SEL_W  (SEL_W)
    ) u_mux (
        .req_n   (req_n),
        .sw_trig (sw_trig),
        .src_sel (src_sel),
        .pick    (pick)
    );

    dreq_sync #(
        .STAGES (STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_n     (pick.line_n),
        .first_n (sync_first_n),
        .q_n     (sync_n)
    );

    dreq_detect u_det (
        .clk    (clk),
        .rst    (rst),
        .sense  (sense),
        .sync_n (sync_n),
        .sw_hit (pick.sw_hit),
        .clr    (req_clr),
        .flag_q (req_flag)
    );

endmodule

// File: rtl/dreq_front_chk.sv
module dreq_front_chk #(
    parameter int SEL_W   = 6,
    parameter int NUM_SRC = 37
) (
    input logic             clk,
    input logic             rst,
    input logic [SEL_W-1:0] src_sel,
    input logic             sense_lvl,
    input logic             req_clr,
    input logic             req_flag,
    input logic             raw_n,
    input logic             sw_hit,
    input logic             first_n,
    input logic             sync_n
);

    // R9
    reset_clear_chk: assert property (@(posedge clk) rst |=> !req_flag);

    // R2
    no_source_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(src_sel) >= NUM_SRC) |-> (raw_n && !sw_hit));

    // R3
    sync_entry_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (first_n == $past(raw_n)));

    // R4
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sense_lvl && req_flag && !req_clr) |=> req_flag);

    // R6
    level_set_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(req_flag) && $past(sense_lvl) && !$past(sw_hit))
        |-> (!$past(sync_n) && !$past(sync_n, 2)));

    // R7
    level_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (sense_lvl && sync_n && !sw_hit) |=> !req_flag);

    // R8
    sw_set_chk: assert property (@(posedge clk) disable iff (rst)
        sw_hit |=> req_flag);

endmodule

bind dreq_front dreq_front_chk #(
    .SEL_W   (SEL_W),
    .NUM_SRC (NUM_SRC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_sel   (src_sel),
    .sense_lvl (sense_lvl),
    .req_clr   (req_clr),
    .req_flag  (req_flag),
    .raw_n     (pick.line_n),
    .sw_hit    (pick.sw_hit),
    .first_n   (sync_first_n),
    .sync_n    (sync_n)
);

// File: tb/dreq_front_bench.sv
module dreq_front_bench;

    localparam int NHW  = 36;
    localparam int NSRC = NHW + 1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NHW-1:0] lines = '1;
    logic           sw = 1'b0;
    logic [5:0]     sel = '0;
    logic           mode = 1'b0;
    logic           clr = 1'b0;
    logic           flag;

    int nchk = 0;
    int nbad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dreq_front u_dreq_front (
        .clk       (clk),
        .rst       (rst),
        .req_n     (lines),
        .sw_trig   (sw),
        .src_sel   (sel),
        .sense_lvl (mode),
        .req_clr   (clr),
        .req_flag  (flag)
    );

    task automatic chk(input logic exp, input string req, input string what, input int code);
        nchk++;
        if (flag !== exp) begin
            nbad++;
            $display("FAIL %s %s code=%0d: got %b expected %b", req, what, code, flag, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clr;
        clr = 1'b1;
        tick(1);
        clr = 1'b0;
    endtask

    task automatic others_low(input int c);
        lines = '1;
        for (int i = 0; i < NHW; i++) if (i != c - 1) lines[i] = 1'b0;
        tick(4);
        chk(1'b0, (c >= 1 && c <= NHW) ? "R1" : "R2", "unselected lines low", c);
        lines = '1;
        tick(4);
        chk(1'b0, (c >= 1 && c <= NHW) ? "R1" : "R2", "unselected lines rise", c);
    endtask

    task automatic edge_code(input int c);
        sel = 6'(c);
        lines = '1;
        tick(4);
        pulse_clr;
        tick(1);
        chk(1'b0, "R9", "idle before pattern", c);
        others_low(c);
        if (c >= 1 && c <= NHW) begin
            lines[c-1] = 1'b0;
            tick(2);
            chk(1'b0, "R3", "too early", c);
            tick(1);
            chk(1'b1, "R3", "edge latency", c);
            lines[c-1] = 1'b1;
            tick(4);
            chk(1'b1, "R4", "hold after rise", c);
            lines[c-1] = 1'b0;
            tick(4);
            chk(1'b1, "R4", "hold while low", c);
            lines[c-1] = 1'b1;
            tick(4);
            pulse_clr;
            chk(1'b0, "R5", "cleared by strobe", c);
        end else if (c == 0) begin
            sw = 1'b1;
            tick(1);
            sw = 1'b0;
            chk(1'b1, "R8", "software set edge sense", c);
            tick(3);
            chk(1'b1, "R4", "software request held", c);
            pulse_clr;
            chk(1'b0, "R5", "cleared by strobe", c);
        end else begin
            sw = 1'b1;
            tick(1);
            sw = 1'b0;
            chk(1'b0, "R2", "software trigger ignored", c);
            tick(3);
            chk(1'b0, "R2", "still no request", c);
        end
    endtask

    task automatic level_code(input int c);
        sel = 6'(c);
        lines = '1;
        tick(4);
        chk(1'b0, "R7", "idle level sense", c);
        others_low(c);
        if (c >= 1 && c <= NHW) begin
            lines[c-1] = 1'b0;
            tick(1);
            lines[c-1] = 1'b1;
            for (int k = 0; k < 5; k++) begin
                tick(1);
                chk(1'b0, "R6", "single low sample", c);
            end
            lines[c-1] = 1'b0;
            tick(3);
            chk(1'b0, "R6", "too early", c);
            tick(1);
            chk(1'b1, "R6", "level latency", c);
            pulse_clr;
            chk(1'b1, "R10", "strobe ignored", c);
            tick(2);
            chk(1'b1, "R6", "held while low", c);
            lines[c-1] = 1'b1;
            tick(2);
            chk(1'b1, "R7", "not yet dropped", c);
            tick(1);
            chk(1'b0, "R7", "dropped", c);
        end else if (c == 0) begin
            sw = 1'b1;
            tick(1);
            sw = 1'b0;
            chk(1'b1, "R8", "software set level sense", c);
            tick(1);
            chk(1'b0, "R8", "one-cycle request", c);
        end else begin
            sw = 1'b1;
            tick(1);
            sw = 1'b0;
            chk(1'b0, "R2", "software trigger ignored", c);
        end
    endtask

    initial begin
        tick(3);
        chk(1'b0, "R9", "flag during reset", -1);
        rst = 1'b0;
        tick(5);
        chk(1'b0, "R9", "no false request after reset", -1);

        mode = 1'b0;
        for (int c = 0; c < 64; c++) edge_code(c);

        // R5: a new falling edge at the same edge as the strobe keeps the flag
        sel = 6'd1;
        lines = '1;
        tick(4);
        pulse_clr;
        lines[0] = 1'b0;
        tick(3);
        chk(1'b1, "R5", "first request", 1);
        lines[0] = 1'b1;
        tick(4);
        lines[0] = 1'b0;
        tick(2);
        clr = 1'b1;
        tick(1);
        clr = 1'b0;
        chk(1'b1, "R5", "edge coincident with strobe", 1);
        pulse_clr;
        chk(1'b0, "R5", "later strobe clears", 1);
        lines = '1;
        tick(4);

        mode = 1'b1;
        for (int c = 0; c < 64; c++) level_code(c);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++;
            nbad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
            $finish;
        end
    end

endmodule